// File: doc/BRIEF.md
# Three-Level Pulse Command Decoder

This block turns one three-level control line into count-up, count-down and store commands. An analog front end compares the line against thresholds and presents three flags that are synchronous to the clock. One flag says the line is above the high threshold, one says it is below the low threshold, and one says it is above the program level. When neither the high flag nor the low flag is set, the line sits at its idle mid level, which is where a tristated driver leaves it. A one-cycle microsecond tick is the time base for every window.

A pulse is a trip from mid to one rail and back to mid. A trip to the low rail asks for a count up. A trip to the high rail asks for a count down. The block reports a pulse only after the line is back at mid, and only if the pulse was long enough and was preceded by enough idle time. Holding the line above the program level for long enough gives a single store request. The whole excursion is then used up as a store, so it yields no count when the line falls back. All decoding stops while the enable input is low.

Top module: `pulse_cmd_decoder`

## Requirements
- R1: The line level is decoded from the flags as follows. `above_prog_i`=1 is program level. Otherwise `above_hi_i`=1 is high, `below_lo_i`=1 is low, and both level flags clear is mid. A valid mid→low→mid pulse gives one `up_o` strobe, and a valid mid→high→mid pulse gives one `down_o` strobe.
- R2: Each command strobe is one clock wide. `up_o` or `down_o` is asserted in the cycle after the first clock edge that samples the line back at mid, and never while the excursion is still in progress. At most one strobe is active in any cycle.
- R3: Excursion width is the number of ticks sampled after the edge that first sees the excursion, up to but not including the edge that sees mid again. A width of `PULSE_TICKS` or more is valid. A shorter width, including a glitch one cycle long, produces no command.
- R4: An excursion is counted only if at least `GAP_TICKS` ticks of mid level were seen since the previous excursion ended, or since reset or enable. Otherwise the whole excursion is ignored.
- R5: With the program flag set, a tick that brings the held time above `PROG_TICKS` ticks gives exactly one `store_o` strobe. A held time of `PROG_TICKS` ticks or less gives none. Holding the line longer gives no second strobe.
- R6: An excursion that reaches the program level never gives `down_o`, even when it passes back through the high level on its way to mid.
- R7: If the high and low flags are set together, that excursion gives no command, and the block waits for mid before it decodes again.
- R8: While `en_i` is low, no strobe is issued and all inputs are ignored. Once `en_i` rises, the idle-time rule of R4 starts afresh.
- R9: After reset all three strobes are low and the idle-time count is zero.
- R10: The window counters saturate, so an excursion far longer than every threshold still decodes as a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Decoder enable |
| tick_i | input | 1 | One-cycle microsecond time base |
| above_hi_i | input | 1 | Line above high threshold |
| below_lo_i | input | 1 | Line below low threshold |
| above_prog_i | input | 1 | Line above program level |
| up_o | output | 1 | Count-up strobe |
| down_o | output | 1 | Count-down strobe |
| store_o | output | 1 | Store-request strobe |

## Verification
Directed pulses sit exactly on the width, idle-gap and program-hold thresholds and one tick below them. This separates an off-by-one in the tick counting from a fault in the comparisons. Other directed cases cover a one-cycle glitch, a store that passes through the high level, both rails flagged at once, and pulses sent while the block is disabled. These separate the paths that lead to mid without a command from the path that emits one. Random sequences mix rail, width and idle gap, and each result is compared with running totals that a bench model computes from the rules above. This catches a wrong direction, a stale arming flag and a repeated store.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [2:0] {
    LV_MID,
    LV_HI,
    LV_LO,
    LV_PROG,
    LV_BAD
  } lvl_e;

  typedef enum logic [2:0] {
    ST_MID,
    ST_HI,
    ST_LO,
    ST_PROG,
    ST_HOLD
  } st_e;
endpackage

// File: rtl/pcd_level_classify.sv
module pcd_level_classify
  import pcd_pkg::*;
(
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic above_prog_i,
  output lvl_e lvl_o
);
  always_comb begin
    if (above_hi_i && below_lo_i)  lvl_o = LV_BAD;
    else if (above_prog_i)         lvl_o = below_lo_i ? LV_BAD : LV_PROG;
    else if (above_hi_i)           lvl_o = LV_HI;
    else if (below_lo_i)           lvl_o = LV_LO;
    else                           lvl_o = LV_MID;
  end
endmodule

// File: rtl/pcd_sat_cnt.sv
module pcd_sat_cnt #(
  parameter int MAX = 1,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_o <= '0;
    else if (clr_i)                          cnt_o <= '0;
    else if (inc_i && cnt_o != W'(MAX))      cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == W'(MAX) && !clr_i) |=> cnt_o == W'(MAX));
endmodule

// File: rtl/pulse_cmd_decoder.sv
module pulse_cmd_decoder
  import pcd_pkg::*;
#(
  parameter int PULSE_TICKS = 200,
  parameter int GAP_TICKS   = 10,
  parameter int PROG_TICKS  = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic above_prog_i,
  output logic up_o,
  output logic down_o,
  output logic store_o
);
  localparam int EXC_MAX = (PULSE_TICKS > PROG_TICKS + 1) ? PULSE_TICKS : PROG_TICKS + 1;
  localparam int EW      = $clog2(EXC_MAX + 1);
  localparam int GW      = $clog2(GAP_TICKS + 1);

  lvl_e lvl;
  st_e  st_q, st_d;
  logic armed_q, armed_d, stored_q, stored_d;
  logic up_d, dn_d, sto_d;
  logic exc_clr, exc_inc, gap_clr, gap_inc;
  logic [EW-1:0] exc_cnt;
  logic [GW-1:0] gap_cnt;
  logic wide_ok, gap_ok, prog_hit;

  pcd_level_classify u_cls (
    .above_hi_i  (above_hi_i),
    .below_lo_i  (below_lo_i),
    .above_prog_i(above_prog_i),
    .lvl_o       (lvl)
  );

  // one counter serves every excursion kind; only one is ever open
  pcd_sat_cnt #(.MAX(EXC_MAX), .W(EW)) u_exc_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (exc_clr),
    .inc_i (exc_inc),
    .cnt_o (exc_cnt)
  );

  pcd_sat_cnt #(.MAX(GAP_TICKS), .W(GW)) u_gap_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (gap_clr),
    .inc_i (gap_inc),
    .cnt_o (gap_cnt)
  );

  assign wide_ok  = exc_cnt >= EW'(PULSE_TICKS);
  assign gap_ok   = gap_cnt == GW'(GAP_TICKS);
  assign prog_hit = exc_cnt == EW'(PROG_TICKS);

  assign gap_inc = en_i && tick_i && st_q == ST_MID && lvl == LV_MID;
  assign gap_clr = !en_i || st_q != ST_MID || lvl != LV_MID;

  always_comb begin
    st_d     = st_q;
    armed_d  = armed_q;
    stored_d = stored_q;
    up_d     = 1'b0;
    dn_d     = 1'b0;
    sto_d    = 1'b0;
    exc_clr  = 1'b0;
    exc_inc  = 1'b0;
    unique case (st_q)
      ST_MID: begin
        unique case (lvl)
          LV_HI:   begin st_d = ST_HI; armed_d = gap_ok; exc_clr = 1'b1; end
          LV_LO:   begin st_d = ST_LO; armed_d = gap_ok; exc_clr = 1'b1; end
          LV_PROG: begin st_d = ST_PROG; stored_d = 1'b0; exc_clr = 1'b1; end
          LV_BAD:  st_d = ST_HOLD;
          default: ;
        endcase
      end
      ST_HI: begin
        unique case (lvl)
          LV_HI:   exc_inc = tick_i;
          LV_MID:  begin st_d = ST_MID; dn_d = armed_q && wide_ok; end
          LV_PROG: begin st_d = ST_PROG; stored_d = 1'b0; exc_clr = 1'b1; end
          default: st_d = ST_HOLD;
        endcase
      end
      ST_LO: begin
        unique case (lvl)
          LV_LO:   exc_inc = tick_i;
          LV_MID:  begin st_d = ST_MID; up_d = armed_q && wide_ok; end
          default: st_d = ST_HOLD;
        endcase
      end
      ST_PROG: begin
        unique case (lvl)
          LV_PROG: begin
            exc_inc = tick_i;
            if (tick_i && prog_hit && !stored_q) begin
              sto_d    = 1'b1;
              stored_d = 1'b1;
            end
          end
          LV_HI:   ;                  // falling back through high: consumed
          LV_MID:  st_d = ST_MID;
          default: st_d = ST_HOLD;
        endcase
      end
      ST_HOLD: if (lvl == LV_MID) st_d = ST_MID;
      default: st_d = ST_MID;
    endcase
    if (!en_i) begin
      st_d     = ST_MID;
      armed_d  = 1'b0;
      stored_d = 1'b0;
      up_d     = 1'b0;
      dn_d     = 1'b0;
      sto_d    = 1'b0;
      exc_clr  = 1'b1;
      exc_inc  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_MID;
      armed_q  <= 1'b0;
      stored_q <= 1'b0;
      up_o     <= 1'b0;
      down_o   <= 1'b0;
      store_o  <= 1'b0;
    end else begin
      st_q     <= st_d;
      armed_q  <= armed_d;
      stored_q <= stored_d;
      up_o     <= up_d;
      down_o   <= dn_d;
      store_o  <= sto_d;
    end
  end

  assert_one_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_o, down_o, store_o}));

  assert_strobe_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o || down_o) |=> !(up_o || down_o));

  assert_down_trail_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_o |-> ($past(!above_hi_i && !below_lo_i && !above_prog_i) && $past(st_q == ST_HI)));

  assert_up_trail_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> ($past(!above_hi_i && !below_lo_i && !above_prog_i) && $past(st_q == ST_LO)));

  assert_store_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> $past(above_prog_i && tick_i));

  assert_hold_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |=> !(up_o || down_o || store_o));

  assert_en_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(up_o || down_o || store_o));
endmodule

// File: tb/sim_pulse_cmd_decoder.sv
module sim_pulse_cmd_decoder;
  localparam int PT = 12;
  localparam int GT = 4;
  localparam int RT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic hi = 1'b0, lo = 1'b0, pr = 1'b0;
  logic tick;
  logic up, dn, st;
  logic [1:0] ph = 2'd0;

  always #4 clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;
  assign tick = (ph == 2'd2);

  pulse_cmd_decoder #(.PULSE_TICKS(PT), .GAP_TICKS(GT), .PROG_TICKS(RT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .above_hi_i(hi), .below_lo_i(lo), .above_prog_i(pr),
    .up_o(up), .down_o(dn), .store_o(st)
  );

  int n_up = 0, n_dn = 0, n_st = 0;
  int e_up = 0, e_dn = 0, e_st = 0;
  int gap_p = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (up) n_up++;
    if (dn) n_dn++;
    if (st) n_st++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_totals(input string req);
    check(req, "up count", n_up, e_up);
    check(req, "down count", n_dn, e_dn);
    check(req, "store count", n_st, e_st);
  endtask

  // 0 mid, 1 high, 2 low, 3 program, 4 both rails
  task automatic set_lvl(input int k);
    hi = (k == 1 || k == 3 || k == 4);
    lo = (k == 2 || k == 4);
    pr = (k == 3);
  endtask

  task automatic periods(input int p);
    repeat (p * 4) @(negedge clk);
  endtask

  task automatic excursion(input string req, input int kind, input int k, input int midp);
    bit armed;
    armed = (gap_p >= GT);
    set_lvl(kind); periods(k);
    set_lvl(0);    periods(midp);
    if (kind == 1 && armed && k >= PT) e_dn++;
    if (kind == 2 && armed && k >= PT) e_up++;
    if (kind == 3 && k > RT) e_st++;
    gap_p = midp;
    check_totals(req);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "up_o", int'(up), 0);
    check("R9", "down_o", int'(dn), 0);
    check("R9", "store_o", int'(st), 0);
    rst_n = 1'b1;
    @(negedge clk);
    while (ph != 2'd0) @(negedge clk);
    en = 1'b1;
    periods(10);
    gap_p = 10;

    // R1: direction
    excursion("R1", 1, PT + 2, 6);
    excursion("R1", 2, PT + 2, 6);

    // R2: strobe only after return, exactly one cycle
    set_lvl(1); periods(PT + 1);
    check("R2", "down_o before return", int'(dn), 0);
    set_lvl(0);
    @(negedge clk);
    check("R2", "down_o after return", int'(dn), 1);
    @(negedge clk);
    check("R2", "down_o second cycle", int'(dn), 0);
    repeat (4 * 6 - 2) @(negedge clk);
    e_dn++; gap_p = 6;
    check_totals("R2");

    // R3: width boundaries and glitch
    excursion("R3", 1, PT, 6);
    excursion("R3", 2, PT - 1, 6);
    set_lvl(2); @(negedge clk);
    set_lvl(0); repeat (4 * 6 - 1) @(negedge clk);
    gap_p = 6;
    check_totals("R3");

    // R4: idle gap boundaries
    excursion("R4", 1, PT + 2, GT - 1);
    excursion("R4", 2, PT + 2, GT);
    excursion("R4", 1, PT + 2, 6);

    // R5: program hold boundaries, single store
    excursion("R5", 3, RT, 6);
    excursion("R5", 3, RT + 1, 6);
    excursion("R5", 3, 3 * RT, 6);

    // R6: store via high, no down on the way back
    set_lvl(1); periods(2);
    set_lvl(3); periods(RT + 2);
    set_lvl(1); periods(PT + 2);
    set_lvl(0); periods(6);
    e_st++; gap_p = 6;
    check_totals("R6");

    // R7: both rails flagged
    excursion("R7", 4, PT + 2, 6);
    set_lvl(2); periods(PT + 2);
    set_lvl(4); periods(1);
    set_lvl(2); periods(2);
    set_lvl(0); periods(6);
    gap_p = 6;
    check_totals("R7");

    // R8: disabled inputs ignored, gap restarts on enable
    en = 1'b0;
    set_lvl(1); periods(PT + 2);
    set_lvl(0); periods(GT + 1);
    set_lvl(3); periods(RT + 3);
    set_lvl(0); periods(2);
    check_totals("R8");
    en = 1'b1;
    periods(GT - 1);
    gap_p = GT - 1;
    excursion("R8", 1, PT + 2, 6);
    excursion("R8", 2, PT + 2, 6);

    // R10: far beyond every threshold
    excursion("R10", 2, 6 * PT, 6);
    excursion("R10", 1, 6 * PT, 6);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int kind, k, midp;
      kind = 1 + int'($urandom % 4);
      k    = 1 + int'($urandom % (2 * PT));
      midp = 1 + int'($urandom % (2 * GT));
      if (kind == 3)      excursion("R5", kind, k, midp);
      else if (kind == 4) excursion("R7", kind, k, midp);
      else                excursion("R3", kind, k, midp);
    end

    done = 1'b1;
    finish_run();
  end
endmodule